// File: doc/BRIEF.md
# Retimed Coin Credit Gate

This controller adds up coins dropped into a slot and raises a single `open_o` flag once the deposit reaches fifteen cents. Only two kinds of coin are accepted. A nickel is worth five cents and a dime ten. Each coin arrives as a one-cycle pulse on its own pin. The deposit is held as a credit count in coin units of five cents. The count runs from 0 to a price of 3 units, and anything past the price is clipped to it. Once the price is reached the credit stays there and ignores further coins until a synchronous reset brings it back to zero.

The flag is retimed. The next-state logic already knows whether the coming credit will be at the price. That comparison is loaded into an output flip-flop on the same edge that loads the credit. As a result `open_o` leaves a register with no decode after it, and it rises and falls on exactly the cycles where a decoded Moore flag (credit equals price) would. A parameter selects the decoded variant instead, so the two outputs can be compared.

The coin pins are plain control strobes, not a data stream. Every pulse is taken on the edge where it is seen, so there is no valid/ready handshake and no back-pressure.

Top module: `coin_gate_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the credit and `open_o` are both zero after that edge.
- R2: Below the price, a nickel alone adds one unit (five cents) to the credit at the next edge.
- R3: Below the price, a dime alone adds two units (ten cents) when the sum stays under the price.
- R4: A coin that would carry the credit to or past the price sets the credit to exactly the price, so `open_o` is high after that edge.
- R5: With no coin and no reset, the credit and `open_o` keep their values.
- R6: Once the credit is at the price, `open_o` stays high and coins have no effect until reset.
- R7: A nickel and a dime in the same cycle count as fifteen cents, so `open_o` is high after that edge from any credit.
- R8: `open_o` is high on exactly the cycles where the credit register equals the price, so the retimed and decoded variants give identical waveforms.
- R9: Reset wins over coins that arrive in the same cycle. A reset cycle with both coins leaves zero credit, and a single nickel afterwards does not open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of credit and flag |
| nickel_i | input | 1 | One-cycle pulse: a five-cent coin was accepted |
| dime_i | input | 1 | One-cycle pulse: a ten-cent coin was accepted |
| open_o | output | 1 | High while the deposit has reached the price; driven by a flip-flop in the retimed variant |

## Verification
A wrong credit value shows only through when `open_o` rises. The flag comes one coin too early or too late on the edge after the coin that should complete fifteen cents. It can also stay low after a nickel-and-dime cycle, or stay low after a reset followed by coins. From any reachable credit, at most three nickels expose a bad count. A wrong value in the output flip-flop shows in the very next cycle as a mismatch against the decoded variant running beside it. The sweep starts from every credit, applies every coin pair, and then runs a long random run compared against an arithmetic model.

// File: rtl/coin_gate_pkg.sv
package coin_gate_pkg;

  // Value of one cycle's coin strobes, in coin units.
  function automatic int unsigned coin_units(
    input logic        nickel,
    input logic        dime,
    input int unsigned nickel_val,
    input int unsigned dime_val
  );
    coin_units = (nickel ? nickel_val : 0) + (dime ? dime_val : 0);
  endfunction

endpackage

// File: rtl/coin_credit_next.sv
module coin_credit_next #(
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned PRICE_UNITS  = 3,
  localparam int unsigned CW = $clog2(PRICE_UNITS + 1),
  localparam int unsigned SW = $clog2(PRICE_UNITS + NICKEL_UNITS + DIME_UNITS + 1)
) (
  input  logic [CW-1:0] credit_i,
  input  logic          nickel_i,
  input  logic          dime_i,
  output logic [CW-1:0] credit_nx,
  output logic          at_price_nx
);
  import coin_gate_pkg::*;

  localparam logic [CW-1:0] PRICE_C = CW'(PRICE_UNITS);
  localparam logic [SW-1:0] PRICE_S = SW'(PRICE_UNITS);

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(credit_i) + SW'(coin_units(nickel_i, dime_i, NICKEL_UNITS, DIME_UNITS));
    if (credit_i == PRICE_C)   credit_nx = PRICE_C;   // latched until reset
    else if (sum >= PRICE_S)   credit_nx = PRICE_C;   // clip at the price
    else                       credit_nx = sum[CW-1:0];
    at_price_nx = (credit_nx == PRICE_C);
  end
endmodule

// File: rtl/coin_credit_reg.sv
module coin_credit_reg #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] d,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/gate_open_reg.sv
module gate_open_reg (
  input  logic clk,
  input  logic rst,
  input  logic open_nx,
  output logic open_q
);
  always_ff @(posedge clk) begin
    if (rst) open_q <= 1'b0;
    else     open_q <= open_nx;
  end
endmodule

// File: rtl/coin_gate_ctrl.sv
module coin_gate_ctrl #(
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned PRICE_UNITS  = 3,
  parameter bit          RETIME_OUT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);
  localparam int unsigned CW = $clog2(PRICE_UNITS + 1);

  logic [CW-1:0] credit_q;
  logic [CW-1:0] credit_nx;
  logic          at_price_nx;

  coin_credit_next #(
    .NICKEL_UNITS(NICKEL_UNITS),
    .DIME_UNITS  (DIME_UNITS),
    .PRICE_UNITS (PRICE_UNITS)
  ) u_next (
    .credit_i   (credit_q),
    .nickel_i   (nickel_i),
    .dime_i     (dime_i),
    .credit_nx  (credit_nx),
    .at_price_nx(at_price_nx)
  );

  coin_credit_reg #(.CW(CW)) u_credit (
    .clk(clk),
    .rst(rst),
    .d  (credit_nx),
    .q  (credit_q)
  );

  generate
    if (RETIME_OUT) begin : g_retimed
      gate_open_reg u_open (
        .clk    (clk),
        .rst    (rst),
        .open_nx(at_price_nx),
        .open_q (open_o)
      );
    end else begin : g_decoded
      logic unused_nx;
      assign unused_nx = at_price_nx;
      assign open_o = (credit_q == CW'(PRICE_UNITS));
    end
  endgenerate
endmodule

// File: rtl/coin_gate_ctrl_chk.sv
module coin_gate_ctrl_chk #(
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned PRICE_UNITS  = 3,
  localparam int unsigned CW = $clog2(PRICE_UNITS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          nickel_i,
  input logic          dime_i,
  input logic          open_o,
  input logic [CW-1:0] credit
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (credit == '0 && !open_o));

  // R9
  reset_wins_chk: assert property (@(posedge clk)
    (rst && (nickel_i || dime_i)) |=> (credit == '0 && !open_o));

  // R2
  nickel_step_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && !dime_i && int'(credit) < PRICE_UNITS) |=>
      (int'(credit) == ((int'($past(credit)) + NICKEL_UNITS >= PRICE_UNITS)
                        ? PRICE_UNITS : int'($past(credit)) + NICKEL_UNITS)));

  // R3
  dime_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dime_i && !nickel_i && int'(credit) < PRICE_UNITS) |=>
      (int'(credit) == ((int'($past(credit)) + DIME_UNITS >= PRICE_UNITS)
                        ? PRICE_UNITS : int'($past(credit)) + DIME_UNITS)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> ($stable(credit) && $stable(open_o)));

  // R6
  open_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    open_o |=> open_o);

  // R7
  both_coins_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && dime_i) |=> open_o);

  // R8
  open_tracks_credit_chk: assert property (@(posedge clk) disable iff (rst)
    open_o == (int'(credit) == PRICE_UNITS));
endmodule

bind coin_gate_ctrl coin_gate_ctrl_chk #(
  .NICKEL_UNITS(NICKEL_UNITS),
  .DIME_UNITS  (DIME_UNITS),
  .PRICE_UNITS (PRICE_UNITS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .nickel_i(nickel_i),
  .dime_i  (dime_i),
  .open_o  (open_o),
  .credit  (credit_q)
);

// File: tb/test_coin_gate_ctrl.sv
module test_coin_gate_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic open_rt;
  logic open_mo;

  int n_chk  = 0;
  int n_fail = 0;
  int m_cents = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  coin_gate_ctrl #(.RETIME_OUT(1'b1)) i_coin_gate_ctrl (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .open_o(open_rt));

  coin_gate_ctrl #(.RETIME_OUT(1'b0)) i_coin_gate_ctrl_moore (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .open_o(open_mo));

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, update the model, return at the next falling edge.
  task automatic step(input bit r, input bit n, input bit d);
    rst = r; nickel = n; dime = d;
    if (r) m_cents = 0;
    else if (m_cents != 15) begin
      m_cents += (n ? 5 : 0) + (d ? 10 : 0);
      if (m_cents > 15) m_cents = 15;
    end
    @(negedge clk);
    rst = 1'b0; nickel = 1'b0; dime = 1'b0;
  endtask

  function automatic logic exp_open();
    return (m_cents == 15);
  endfunction

  initial begin
    string tag;
    @(negedge clk);
    step(1, 0, 0);
    chk("R1", open_rt, 1'b0, "reset state");

    // Sweep: every start credit x every coin pair.
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        step(1, 0, 0);
        chk("R1", open_rt, 1'b0, "after reset");
        for (int k = 0; k < s; k++) step(0, 1, 0);
        chk("R2", open_rt, exp_open(), "nickels to start credit");
        if (s == 3)                 tag = "R6";
        else if (c == 3)            tag = "R7";
        else if (c == 1)            tag = (s == 2) ? "R4" : "R2";
        else if (c == 2)            tag = (s >= 1) ? "R4" : "R3";
        else                        tag = "R5";
        step(0, c[0], c[1]);
        chk(tag, open_rt, exp_open(), $sformatf("start %0d coins %0d", s * 5, c));
        step(0, 0, 0);
        chk("R5", open_rt, exp_open(), "idle hold");
        chk("R8", open_mo, open_rt, "variants agree in sweep");
      end
    end

    // R3: a single dime from zero gives ten cents, then a nickel opens.
    step(1, 0, 0);
    step(0, 0, 1);
    chk("R3", open_rt, 1'b0, "dime from zero");
    step(0, 1, 0);
    chk("R2", open_rt, 1'b1, "nickel after dime");

    // R6: coins at the price have no effect; the flag stays high.
    for (int k = 0; k < 4; k++) begin
      step(0, k[0], k[1]);
      chk("R6", open_rt, 1'b1, "coins at price ignored");
    end

    // R9: reset with both coins at ten cents clears credit.
    step(1, 0, 0);
    step(0, 0, 1);
    step(1, 1, 1);
    chk("R9", open_rt, 1'b0, "reset with both coins");
    step(0, 1, 0);
    chk("R9", open_rt, 1'b0, "nickel after reset does not open");
    step(0, 1, 0);
    chk("R9", open_rt, 1'b0, "second nickel after reset");
    step(0, 1, 0);
    chk("R9", open_rt, 1'b1, "third nickel opens");

    // R8: random lockstep against model and decoded variant.
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 12) == 0, $urandom % 3 == 0, $urandom % 4 == 0);
      chk("R8", open_rt, exp_open(), $sformatf("random cycle %0d vs model", i));
      chk("R8", open_rt, open_mo, $sformatf("random cycle %0d vs decoded", i));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule